// File: doc/BRIEF.md
# Host-Filled Transmit Frame Buffer

This block holds a single outgoing frame that the host loads directly, one 32-bit word per write strobe, with no memory DMA in between. While the host writes, the block tallies how many frame bytes it has received. A frame whose length is not a multiple of four closes with a final word that carries a valid-byte count, and only the low bytes named by that count are kept. The data port has no read path, so host reads of it cannot return stored frame data. A frame may be at most 1518 bytes long. A write that would push the frame past that limit is discarded and raises an error flag.

After the host issues a send command, the stored frame leaves as a byte stream toward a MAC transmitter. The stream uses a valid/ready handshake and flags its final byte. Bytes within each word leave lowest lane first. When the final byte is accepted, the block pulses `done`, clears its byte tally and reports itself idle. Only then can the next frame be loaded. While an external DMA transmit path owns the buffer, host writes and send commands are refused so that they cannot disturb a frame in flight.

Top module: `host_txfifo`

## Requirements
- R1: After reset, `byte_count` is 0, `idle` is 1, and `tx_valid`, `tx_last`, `done` and `len_err` are all 0.
- R2: An accepted write with `cnt_en` low adds 4 to `byte_count`, visible on the cycle after the write.
- R3: An accepted write with `cnt_en` high and `last_cnt` set to 1, 2 or 3 adds that many bytes, and only lanes 0 up to `last_cnt`-1 of the word join the frame. A `last_cnt` of 0 with `cnt_en` high counts as a full 4-byte word.
- R4: After a partial final word has been accepted, later writes to the same frame are dropped and set `len_err`.
- R5: A write that would take `byte_count` above 1518 is dropped, `byte_count` keeps its value, and `len_err` is set. Exactly 1518 bytes are accepted without error.
- R6: Host writes are ignored, without changing `byte_count` or `len_err`, while `dma_active` is high or while a frame is being sent.
- R7: A `send` pulse while not sending, with `dma_active` low and `byte_count` nonzero, makes `tx_valid` high on the next cycle. A `send` with an empty buffer or with `dma_active` high has no effect.
- R8: Frame bytes leave in write order, with lane 0 (bits 7:0) of each word first. `tx_data` and `tx_valid` hold while `tx_ready` is low.
- R9: `tx_last` is high only together with the final byte of the frame. For a 1-byte frame, that is the first byte.
- R10: On the cycle after the final byte's handshake, `done` is high for exactly one cycle. In that same cycle `byte_count` is 0, `idle` is 1, `tx_valid` is 0 and `len_err` is cleared, and a new frame may be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 32 | Host write word, lane 0 in bits 7:0 |
| cnt_en | input | 1 | Marks this write as a final word with a valid-byte count |
| last_cnt | input | 2 | Valid bytes in the final word (1..3; 0 means 4) |
| dma_active | input | 1 | DMA transmit path owns the buffer; host access refused |
| send | input | 1 | Send command pulse |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_valid | output | 1 | A frame byte is presented |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Presented byte is the last of the frame |
| done | output | 1 | One-cycle pulse after the last byte is taken |
| idle | output | 1 | Buffer empty and not sending |
| len_err | output | 1 | A write was dropped for length or after a partial word |
| byte_count | output | 11 | Bytes held in the current frame |

## Verification
Every result here is one register stage away from its cause. A write's effect on `byte_count` and `len_err` shows on the cycle after the strobe. `tx_valid` rises on the cycle after `send`. `done` follows the final byte's handshake by one cycle. Each stream byte is due in the same cycle that it is presented. The bench drives inputs on the falling edge and samples one time unit later. So each check sees exactly the state left by the preceding rising edge. During draining, the bench compares each byte only in cycles where it has raised `tx_ready`, and it confirms `done` falls again one cycle after it rises.

// File: rtl/host_txfifo.sv
module host_txfifo #(
  parameter int DW        = 32,
  parameter int MAX_BYTES = 1518,
  localparam int NB    = DW / 8,
  localparam int BW    = $clog2(NB),
  localparam int WORDS = (MAX_BYTES + NB - 1) / NB,
  localparam int AW    = $clog2(WORDS),
  localparam int CW    = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          cnt_en,
  input  logic [BW-1:0] last_cnt,
  input  logic          dma_active,
  input  logic          send,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          done,
  output logic          idle,
  output logic          len_err,
  output logic [CW-1:0] byte_count
);

  logic [DW-1:0] mem [WORDS];
  logic          sending, sealed;
  logic [CW-1:0] rd_ptr;

  wire          partial    = cnt_en && (last_cnt != '0);
  wire [BW:0]   nbytes     = partial ? {1'b0, last_cnt} : (BW+1)'(NB);
  wire [CW:0]   next_total = {1'b0, byte_count} + (CW+1)'(nbytes);
  wire          overflow   = next_total > (CW+1)'(MAX_BYTES);
  wire          host_ok    = host_wr && !sending && !dma_active;
  wire          accept     = host_ok && !sealed && !overflow;
  wire          reject     = host_ok && (sealed || overflow);
  wire          start      = send && !sending && !dma_active && (byte_count != '0);
  wire [AW-1:0] wr_addr    = AW'(byte_count >> BW);
  wire [AW-1:0] rd_addr    = AW'(rd_ptr >> BW);
  wire [DW-1:0] rd_word    = mem[rd_addr];

  assign tx_valid = sending;
  assign tx_data  = rd_word[{rd_ptr[BW-1:0], 3'b000} +: 8];
  assign tx_last  = sending && (rd_ptr == byte_count - CW'(1));
  assign idle     = !sending && (byte_count == '0);

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < NB; i++)
        if (i < int'(nbytes)) mem[wr_addr][i*8 +: 8] <= host_wdata[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending    <= 1'b0;
      sealed     <= 1'b0;
      len_err    <= 1'b0;
      done       <= 1'b0;
      rd_ptr     <= '0;
      byte_count <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        byte_count <= next_total[CW-1:0];
        if (partial) sealed <= 1'b1;
      end
      if (reject) len_err <= 1'b1;
      if (start) begin
        sending <= 1'b1;
        rd_ptr  <= '0;
      end
      if (sending && tx_ready) begin
        if (tx_last) begin
          sending    <= 1'b0;
          sealed     <= 1'b0;
          len_err    <= 1'b0;
          done       <= 1'b1;
          rd_ptr     <= '0;
          byte_count <= '0;
        end else begin
          rd_ptr <= rd_ptr + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/host_txfifo_chk.sv
module host_txfifo_chk #(
  parameter int DW        = 32,
  parameter int MAX_BYTES = 1518,
  localparam int NB = DW / 8,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic [DW-1:0] host_wdata,
  input logic          cnt_en,
  input logic [BW-1:0] last_cnt,
  input logic          dma_active,
  input logic          send,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          done,
  input logic          idle,
  input logic          len_err,
  input logic [CW-1:0] byte_count
);

  a_r5_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CW'(MAX_BYTES));

  a_r6_dma_block: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && !tx_valid) |=> (byte_count == $past(byte_count)));

  a_r7_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (byte_count != '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (done && idle && !len_err));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind host_txfifo host_txfifo_chk #(.DW(DW), .MAX_BYTES(MAX_BYTES)) chk_i (.*);

// File: tb/host_txfifo_tb.sv
module host_txfifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 1518;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_wr = 0, cnt_en = 0, dma_active = 0, send = 0, tx_ready = 0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  last_cnt = '0;
  logic        tx_valid, tx_last, done, idle, len_err;
  logic [7:0]  tx_data;
  logic [10:0] byte_count;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_txfifo dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .cnt_en(cnt_en), .last_cnt(last_cnt), .dma_active(dma_active), .send(send),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .done(done), .idle(idle), .len_err(len_err), .byte_count(byte_count)
  );

  function automatic logic [7:0] fb(int j);
    return 8'((j * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] w, logic en, logic [1:0] n);
    @(negedge clk);
    host_wr = 1; host_wdata = w; cnt_en = en; last_cnt = n;
    @(negedge clk);
    host_wr = 0; cnt_en = 0; last_cnt = '0;
    #1;
  endtask

  task automatic fill(int n);
    for (int k = 0; k < n / 4; k++)
      wr({fb(4*k+3), fb(4*k+2), fb(4*k+1), fb(4*k)}, 0, 2'd0);
    if (n % 4 != 0) begin
      logic [31:0] w = 32'hEEEEEEEE;
      for (int b = 0; b < n % 4; b++) w[b*8 +: 8] = fb((n/4)*4 + b);
      wr(w, 1, 2'(n % 4));
    end
  endtask

  task automatic do_send();
    @(negedge clk); send = 1;
    @(negedge clk); send = 0;
    #1;
    chk(tx_valid == 1, "R7 valid after send", tx_valid, 1);
  endtask

  task automatic drain(int n);
    int i = 0, cyc = 0;
    while (i < n && cyc < 4 * n + 10) begin
      @(negedge clk);
      tx_ready = (cyc % 3 != 2);
      #1;
      if (tx_ready) begin
        chk(tx_data == fb(i), "R8 byte order", tx_data, fb(i));
        chk(tx_last == (i == n - 1), "R9 last flag", tx_last, int'(i == n - 1));
        i++;
      end else begin
        chk(tx_valid == 1, "R8 hold valid", tx_valid, 1);
      end
      cyc++;
    end
    @(negedge clk); tx_ready = 0; #1;
    chk(done == 1, "R10 done pulse", done, 1);
    chk(byte_count == 0, "R10 count cleared", byte_count, 0);
    chk(idle == 1 && tx_valid == 0, "R10 idle", idle, 1);
    chk(len_err == 0, "R10 err cleared", len_err, 0);
    @(negedge clk); #1;
    chk(done == 0, "R10 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(byte_count == 0 && idle == 1, "R1 count/idle", byte_count, 0);
    chk(!tx_valid && !tx_last && !done && !len_err, "R1 outputs low",
        {tx_valid, tx_last, done, len_err}, 0);
  endtask

  task automatic t_full_words();
    wr({fb(3), fb(2), fb(1), fb(0)}, 0, 2'd0);
    chk(byte_count == 4, "R2 first word", byte_count, 4);
    wr({fb(7), fb(6), fb(5), fb(4)}, 0, 2'd0);
    chk(byte_count == 8, "R2 second word", byte_count, 8);
    wr({fb(11), fb(10), fb(9), fb(8)}, 1, 2'd0);
    chk(byte_count == 12, "R3 zero count means four", byte_count, 12);
    do_send();
    drain(12);
  endtask

  task automatic t_partial();
    fill(7);
    chk(byte_count == 7, "R3 partial three", byte_count, 7);
    do_send(); drain(7);
    fill(1);
    chk(byte_count == 1, "R3 partial one", byte_count, 1);
    do_send(); drain(1);
    fill(6);
    chk(byte_count == 6, "R3 partial two", byte_count, 6);
    wr(32'h12345678, 0, 2'd0);
    chk(byte_count == 6, "R4 write after partial dropped", byte_count, 6);
    chk(len_err == 1, "R4 error flag", len_err, 1);
    do_send(); drain(6);
  endtask

  task automatic t_limits();
    fill(MAXB);
    chk(byte_count == MAXB, "R5 max length accepted", byte_count, MAXB);
    chk(len_err == 0, "R5 no error at max", len_err, 0);
    do_send(); drain(MAXB);
    fill(1516);
    wr(32'hDEADBEEF, 0, 2'd0);
    chk(byte_count == 1516, "R5 overflow dropped", byte_count, 1516);
    chk(len_err == 1, "R5 overflow error", len_err, 1);
    do_send(); drain(1516);
  endtask

  task automatic t_blocking();
    @(negedge clk); send = 1;
    @(negedge clk); send = 0; #1;
    chk(tx_valid == 0, "R7 empty send ignored", tx_valid, 0);
    dma_active = 1;
    wr(32'h01020304, 0, 2'd0);
    chk(byte_count == 0 && len_err == 0, "R6 dma refuses write", byte_count, 0);
    dma_active = 0;
    fill(5);
    dma_active = 1;
    @(negedge clk); send = 1;
    @(negedge clk); send = 0; #1;
    chk(tx_valid == 0, "R7 send refused under dma", tx_valid, 0);
    dma_active = 0;
    do_send();
    wr(32'hCAFEF00D, 0, 2'd0);
    chk(byte_count == 5 && len_err == 0, "R6 write while sending refused", byte_count, 5);
    drain(5);
  endtask

  initial begin
    t_reset();
    t_full_words();
    t_partial();
    t_limits();
    t_blocking();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule